// File: doc/BRIEF.md
# Transmit Window Mode Controller

This block chooses between transmit and receive operation for a half-duplex line modem front end. A single active-low request input asks for transmission. The controller synchronises that request and enters transmit mode. It bounds the length of any transmission with a cycle-counted timeout. When the timeout expires while the request is still asserted, the controller falls back to a receive-like hold-off state. It leaves that state only after the request has been released for a qualified minimum time.

From its state the block drives four things: a complementary pair of power-amplifier bias controls, an enable for the analog transmit output stage, and a signal that forces the receive-data output high during transmission. Two test inputs change the timeout. The first swaps the long timeout for a short one. The second switches the timeout off, so that the mode follows the request alone.

Top module: `tx_window_ctrl`

## Requirements
- R1: A request level of 0 seen in receive mode puts the block in transmit mode; `tx_mode` reads 1 after the third rising clock edge that samples the new level (two synchroniser stages plus the state register).
- R2: With both test inputs at 0 and the request held at 0, `tx_mode` stays 1 for exactly TIMEOUT_CYCLES cycles. The block then enters the hold-off state, where `tx_mode` is 0.
- R3: The hold-off state is left for receive mode only after the synchronised request has been 1 for RELEASE_CYCLES consecutive cycles. A release of RELEASE_CYCLES-1 cycles followed by 0 does not re-enter transmit. A release of exactly RELEASE_CYCLES cycles followed by 0 does re-enter transmit.
- R4: `bias_on` is 1 and `bias_on_n` is 0 in transmit mode. In receive mode and in hold-off, `bias_on` is 0 and `bias_on_n` is 1.
- R5: `dac_oe` is 1 only in transmit mode. In receive mode and in hold-off it is 0, which leaves the analog stage in high impedance.
- R6: `rxd_force_hi` is 1 only in transmit mode.
- R7: With `tst_fast` at 1, the transmit limit is FAST_CYCLES instead of TIMEOUT_CYCLES.
- R8: With `tst_noauto` at 1, no timeout occurs. Transmit lasts exactly as long as the request is held at 0.
- R9: After reset the block is in receive mode with `tx_mode`=0, `bias_on`=0, `bias_on_n`=1, `dac_oe`=0 and `rxd_force_hi`=0.
- R10: A request returning to 1 before the limit ends transmit. The length of the transmit window equals the number of cycles the request was held at 0, including a one-cycle request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| txreq_n | input | 1 | Asynchronous request: 0 asks for transmit, 1 for receive |
| tst_fast | input | 1 | Test: use the short transmit limit |
| tst_noauto | input | 1 | Test: disable the automatic fall-back to receive |
| tx_mode | output | 1 | 1 while in transmit mode |
| bias_on | output | 1 | Power-amplifier bias control, high in transmit |
| bias_on_n | output | 1 | Complement of the bias control |
| dac_oe | output | 1 | Enable for the analog transmit output stage |
| rxd_force_hi | output | 1 | Forces the receive-data output to 1 during transmit |

## Verification
The bench builds the block with TIMEOUT_CYCLES=200, FAST_CYCLES=40, RELEASE_CYCLES=23 and two synchroniser stages. The shortened limits let a full timeout, a compressed timeout and a 300-cycle transmit with the timeout bypassed all run in a few thousand cycles. Because the release qualifier keeps its production length of 23 cycles, the release boundary is tested at the exact count the default build uses, both one cycle short and at full length.

// File: rtl/txw_pkg.sv
package txw_pkg;
   typedef enum logic [1:0] {
      MODE_RX      = 2'd0,
      MODE_TX      = 2'd1,
      MODE_HOLDOFF = 2'd2
   } txw_mode_e;
endpackage

// File: rtl/txw_req_sync.sv
module txw_req_sync #(
   parameter int   STAGES    = 2,
   parameter logic RESET_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] sr;

   generate
      if (STAGES < 1) begin : g_bad
         $error("txw_req_sync: STAGES must be at least 1");
      end
      if (STAGES == 1) begin : g_single
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sr <= RESET_VAL;
            else        sr <= d;
         end
      end else begin : g_chain
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sr <= {STAGES{RESET_VAL}};
            else        sr <= {sr[STAGES-2:0], d};
         end
      end
   endgenerate

   assign q = sr[STAGES-1];
endmodule

// File: rtl/txw_tx_timer.sv
module txw_tx_timer #(
   parameter int LONG_CYCLES  = 11059200,
   parameter int SHORT_CYCLES = 5397
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic short_sel,
   output logic expired
);
   localparam int W = $clog2(LONG_CYCLES + 1);
   localparam logic [W-1:0] LONG_LAST  = W'(LONG_CYCLES - 1);
   localparam logic [W-1:0] SHORT_LAST = W'(SHORT_CYCLES - 1);

   generate
      if (SHORT_CYCLES < 1 || SHORT_CYCLES > LONG_CYCLES) begin : g_bad
         $error("txw_tx_timer: SHORT_CYCLES must lie in 1..LONG_CYCLES");
      end
   endgenerate

   logic [W-1:0] cnt;
   logic [W-1:0] last;

   assign last    = short_sel ? SHORT_LAST : LONG_LAST;
   assign expired = run && (cnt >= last);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         cnt <= '0;
      else if (!run)      cnt <= '0;
      else if (!expired)  cnt <= cnt + 1'b1;
   end

   assert_fresh_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(run) |-> cnt == '0);
endmodule

// File: rtl/txw_release_qual.sv
module txw_release_qual #(
   parameter int HOLD_CYCLES = 23
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic req_hi,
   output logic done
);
   localparam int W = $clog2(HOLD_CYCLES + 1);
   localparam logic [W-1:0] LAST = W'(HOLD_CYCLES - 1);

   logic [W-1:0] cnt;

   assign done = en && req_hi && (cnt == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               cnt <= '0;
      else if (!en || !req_hi)  cnt <= '0;
      else if (cnt != LAST)     cnt <= cnt + 1'b1;
   end

   generate
      if (HOLD_CYCLES < 1) begin : g_bad
         $error("txw_release_qual: HOLD_CYCLES must be at least 1");
      end
      if (HOLD_CYCLES >= 2) begin : g_chk
         assert_release_needs_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
            done |-> $past(req_hi) && $past(en));
      end
   endgenerate
endmodule

// File: rtl/tx_window_ctrl.sv
module tx_window_ctrl
   import txw_pkg::*;
#(
   parameter int TIMEOUT_CYCLES = 11059200,
   parameter int FAST_CYCLES    = 5397,
   parameter int RELEASE_CYCLES = 23,
   parameter int SYNC_STAGES    = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic txreq_n,
   input  logic tst_fast,
   input  logic tst_noauto,
   output logic tx_mode,
   output logic bias_on,
   output logic bias_on_n,
   output logic dac_oe,
   output logic rxd_force_hi
);
   generate
      if (TIMEOUT_CYCLES < 1)  begin : g_bad_tmo $error("TIMEOUT_CYCLES must be positive"); end
      if (RELEASE_CYCLES < 1)  begin : g_bad_rel $error("RELEASE_CYCLES must be positive"); end
      if (SYNC_STAGES < 1)     begin : g_bad_syn $error("SYNC_STAGES must be positive"); end
   endgenerate

   txw_mode_e st, st_nx;
   logic      req_hi_s;
   logic      tmr_expired;
   logic      rel_done;

   txw_req_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (txreq_n),
      .q     (req_hi_s)
   );

   txw_tx_timer #(.LONG_CYCLES(TIMEOUT_CYCLES), .SHORT_CYCLES(FAST_CYCLES)) u_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .run       (st == MODE_TX),
      .short_sel (tst_fast),
      .expired   (tmr_expired)
   );

   txw_release_qual #(.HOLD_CYCLES(RELEASE_CYCLES)) u_rel (
      .clk    (clk),
      .rst_n  (rst_n),
      .en     (st == MODE_HOLDOFF),
      .req_hi (req_hi_s),
      .done   (rel_done)
   );

   always_comb begin
      st_nx = st;
      unique case (st)
         MODE_RX:      if (!req_hi_s) st_nx = MODE_TX;
         MODE_TX: begin
            if (req_hi_s)                       st_nx = MODE_RX;
            else if (!tst_noauto && tmr_expired) st_nx = MODE_HOLDOFF;
         end
         MODE_HOLDOFF: if (rel_done) st_nx = MODE_RX;
         default:      st_nx = MODE_RX;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st <= MODE_RX;
      else        st <= st_nx;
   end

   assign tx_mode      = (st == MODE_TX);
   assign bias_on      = tx_mode;
   assign bias_on_n    = ~tx_mode;
   assign dac_oe       = tx_mode;
   assign rxd_force_hi = tx_mode;

   assert_enter_tx_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (st == MODE_RX && !req_hi_s) |=> st == MODE_TX);

   assert_holdoff_blocks_tx_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (st == MODE_HOLDOFF) |=> st != MODE_TX);

   assert_noauto_keeps_tx_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (st == MODE_TX && tst_noauto && !req_hi_s) |=> st == MODE_TX);

   assert_release_ends_tx_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (st == MODE_TX && req_hi_s) |=> st == MODE_RX);
endmodule

// File: tb/tx_window_ctrl_tb_top.sv
module tx_window_ctrl_tb_top;
   localparam int TMO = 200;
   localparam int FST = 40;
   localparam int REL = 23;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic txreq_n = 1'b1;
   logic tst_fast = 1'b0;
   logic tst_noauto = 1'b0;
   logic tx_mode, bias_on, bias_on_n, dac_oe, rxd_force_hi;

   always #5 clk = ~clk;

   tx_window_ctrl #(
      .TIMEOUT_CYCLES (TMO),
      .FAST_CYCLES    (FST),
      .RELEASE_CYCLES (REL),
      .SYNC_STAGES    (2)
   ) dut_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .txreq_n      (txreq_n),
      .tst_fast     (tst_fast),
      .tst_noauto   (tst_noauto),
      .tx_mode      (tx_mode),
      .bias_on      (bias_on),
      .bias_on_n    (bias_on_n),
      .dac_oe       (dac_oe),
      .rxd_force_hi (rxd_force_hi)
   );

   int n_chk = 0;
   int n_fail = 0;
   int exp_len[$];
   string exp_tag[$];
   int run_len = 0;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic expect_window(input int len, input string tag);
      exp_len.push_back(len);
      exp_tag.push_back(tag);
   endtask

   task automatic hold(input logic v, input int n);
      txreq_n = v;
      repeat (n) @(negedge clk);
   endtask

   // Monitor: output pair consistency every cycle and transmit window lengths
   always @(negedge clk) begin
      if (rst_n) begin
         chk(bias_on == tx_mode && bias_on_n == !tx_mode, "R4", {bias_on, bias_on_n}, {tx_mode, !tx_mode});
         chk(dac_oe == tx_mode, "R5", dac_oe, tx_mode);
         chk(rxd_force_hi == tx_mode, "R6", rxd_force_hi, tx_mode);
         if (tx_mode) run_len++;
         else if (run_len > 0) begin
            if (exp_len.size() == 0) chk(1'b0, "R3 unexpected transmit window", run_len, 0);
            else begin
               int e;
               string t;
               e = exp_len.pop_front();
               t = exp_tag.pop_front();
               chk(run_len == e, t, run_len, e);
            end
            run_len = 0;
         end
      end
   end

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      repeat (30000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL R9 watchdog expired actual=%0d expected=%0d", 1, 0);
      finish_run();
   end

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      // R9: reset state
      chk(tx_mode == 1'b0, "R9 tx_mode", tx_mode, 0);
      chk(bias_on == 1'b0 && bias_on_n == 1'b1, "R9 bias", {bias_on, bias_on_n}, 1);
      chk(dac_oe == 1'b0, "R9 dac_oe", dac_oe, 0);
      chk(rxd_force_hi == 1'b0, "R9 rxd_force_hi", rxd_force_hi, 0);

      // R1 latency and R10 normal window of 50 cycles
      expect_window(50, "R10 normal window");
      txreq_n = 1'b0;
      @(negedge clk);
      chk(tx_mode == 1'b0, "R1 after 1 edge", tx_mode, 0);
      @(negedge clk);
      chk(tx_mode == 1'b0, "R1 after 2 edges", tx_mode, 0);
      @(negedge clk);
      chk(tx_mode == 1'b1, "R1 after 3 edges", tx_mode, 1);
      chk(dac_oe == 1'b1 && rxd_force_hi == 1'b1 && bias_on == 1'b1, "R5 R6 R4 in transmit",
          {dac_oe, rxd_force_hi, bias_on}, 7);
      hold(1'b0, 47);
      hold(1'b1, 10);

      // R2: timeout after TMO cycles
      expect_window(TMO, "R2 timeout window");
      hold(1'b0, TMO + 50);
      chk(tx_mode == 1'b0, "R2 hold-off after timeout", tx_mode, 0);
      chk(dac_oe == 1'b0 && bias_on_n == 1'b1 && rxd_force_hi == 1'b0, "R4 R5 R6 in hold-off",
          {dac_oe, bias_on_n, rxd_force_hi}, 2);
      hold(1'b0, 150);

      // R3: a release one cycle short must not re-arm
      hold(1'b1, REL - 1);
      hold(1'b0, 60);
      chk(tx_mode == 1'b0, "R3 short release", tx_mode, 0);
      // R3: a release of exact length re-arms
      hold(1'b1, REL);
      expect_window(60, "R3 exact release re-arms");
      hold(1'b0, 60);
      hold(1'b1, 10);

      // R7: compressed timeout
      tst_fast = 1'b1;
      expect_window(FST, "R7 fast timeout window");
      hold(1'b0, 100);
      chk(tx_mode == 1'b0, "R7 hold-off after fast timeout", tx_mode, 0);
      hold(1'b1, REL + 5);
      tst_fast = 1'b0;

      // R8: timeout bypassed
      tst_noauto = 1'b1;
      expect_window(300, "R8 bypass window");
      hold(1'b0, 300);
      hold(1'b1, 10);
      tst_noauto = 1'b0;

      // R10: one-cycle request
      expect_window(1, "R10 single cycle window");
      hold(1'b0, 1);
      hold(1'b1, 10);

      chk(exp_len.size() == 0, "R10 all windows seen", exp_len.size(), 0);
      finish_run();
   end
endmodule